// File: doc/BRIEF.md
# Backplane reset and fail supervisor

This block watches and drives the reset and failure lines of a shared backplane for a board that may also serve as the backplane's system controller. A low level on the incoming backplane reset line resets the block's own state. It also raises the local halt and reset outputs and keeps them raised for a minimum hold time after the line returns high. In controller mode, a local reset request pulls the backplane reset line low for that same minimum hold.

The shared reset and fail lines are open-collector wires. The block drives each one through a drive-low enable and reads the wire level back on a separate input. Every wire input passes through a two-flop synchronizer. The fail line is pulled low after a global reset. It is also pulled low when another source has held halt high for longer than a timeout. Two register bits can suppress this drive: an enable bit that must be set and an inhibit bit that must be clear.

Two sticky interrupt requests report a new fail assertion from another board and a new AC power-fail assertion. Each request has its own enable and its own write-one-to-clear pulse. In controller mode the block also produces the backplane system clock at one quarter of the main clock rate, together with its output enable. All intervals are parameters counted in main-clock cycles.

Top module: `bkp_rst_supervisor`

## Requirements
- R1: After the power-on reset `rst_n` is released, `loc_halt`, `loc_reset`, `bus_rst_drv`, `irq_fail` and `irq_acf` are 0. `bus_fail_drv` is 1 when `fail_en`=1 and `fail_inhibit`=0, because a global reset arms the fail drive.
- R2: `bus_rst_n_in` low raises `loc_halt` and `loc_reset` by the second clock edge. Both stay high while the line is low. After the line is released they stay high through RST_HOLD+1 further edges and fall at edge RST_HOLD+2.
- R3: When `ctrl_mode`=1, `loc_rst_req_n` low sets `bus_rst_drv` to 1. After the request is released, the drive falls at edge RST_HOLD+2. A new request during the hold restarts the count. When `ctrl_mode`=0 the request has no effect on `bus_rst_drv`.
- R4: A low level on `bus_rst_n_in` clears both interrupt requests and re-arms the fail drive, just as the power-on reset does.
- R5: When `halt_in` is held high, `bus_fail_drv` rises at edge HALT_TIMEOUT+2 after the rise. It falls within three edges after `halt_in` drops. A drop of `halt_in` before the timeout restarts the count from zero.
- R6: The halt timer does not count while `loc_halt` is high, because that halt comes from this block. Once `loc_halt` falls with `halt_in` still high, `bus_fail_drv` rises exactly HALT_TIMEOUT edges later.
- R7: `bus_fail_drv` is 0 whenever `fail_en`=0 or `fail_inhibit`=1. While `fail_en`=0, the armed post-reset fail is discarded.
- R8: A high-to-low change on `bus_fail_n_in` with `irq_fail_en`=1 sets `irq_fail` at the third edge. It is not set when `irq_fail_en`=0, and it is not set when the low level is caused by this block's own `bus_fail_drv`. `irq_fail` stays 1 until an `irq_fail_clr` pulse.
- R9: A high-to-low change on `acfail_n_in` with `irq_acf_en`=1 sets `irq_acf` at the third edge. `irq_acf` stays 1 until an `irq_acf_clr` pulse. Without the enable it is not set.
- R10: When a set and a clear pulse for the same interrupt request fall in the same cycle, the request ends up set.
- R11: `sysclk_oe` equals `ctrl_mode`. `sysclk_drv` has a period of 2^DIV_LOG2 main-clock cycles (4 by default) and a 50 % duty cycle, so every output level lasts 2^(DIV_LOG2-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_rst_n_in | input | 1 | Level of the backplane reset wire, active low |
| loc_rst_req_n | input | 1 | Local reset request, active low |
| halt_in | input | 1 | Halt indication, active high |
| bus_fail_n_in | input | 1 | Level of the backplane fail wire, active low |
| acfail_n_in | input | 1 | AC power-fail line, active low |
| ctrl_mode | input | 1 | Board is the system controller |
| fail_en | input | 1 | Fail drive enable bit |
| fail_inhibit | input | 1 | Fail drive inhibit bit |
| irq_fail_en | input | 1 | Enable for the fail-line interrupt |
| irq_acf_en | input | 1 | Enable for the AC-fail interrupt |
| irq_fail_clr | input | 1 | Write-one-to-clear pulse for irq_fail |
| irq_acf_clr | input | 1 | Write-one-to-clear pulse for irq_acf |
| bus_rst_drv | output | 1 | Pull the backplane reset wire low |
| bus_fail_drv | output | 1 | Pull the backplane fail wire low |
| loc_halt | output | 1 | Local halt output |
| loc_reset | output | 1 | Local reset output |
| sysclk_drv | output | 1 | Divided system clock |
| sysclk_oe | output | 1 | Output enable for the system clock |
| irq_fail | output | 1 | Sticky fail-line interrupt request |
| irq_acf | output | 1 | Sticky AC-fail interrupt request |

## Verification
Two pairs of events can fall in the same cycle. The first is a new fail or AC-fail assertion that sets an interrupt request while software writes the clear pulse for it. The bench provokes this by raising the clear pulse during the cycle in which the synchronized falling level is seen, and it expects the request to remain set. The second is a halt timeout that pulls the shared fail wire low while the fail interrupt is enabled. The bench models the wire as the AND of the other board's level and the block's own release, and it expects no interrupt from this self-caused edge.

// File: rtl/bkp_rst_supervisor.sv
module bkp_rst_supervisor #(
  parameter int unsigned RST_HOLD     = 12_800_000,
  parameter int unsigned HALT_TIMEOUT = 384_000_000,
  parameter int unsigned DIV_LOG2     = 2,
  localparam int HW = $clog2(RST_HOLD + 1),
  localparam int TW = $clog2(HALT_TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst_n_in,
  input  logic loc_rst_req_n,
  input  logic halt_in,
  input  logic bus_fail_n_in,
  input  logic acfail_n_in,
  input  logic ctrl_mode,
  input  logic fail_en,
  input  logic fail_inhibit,
  input  logic irq_fail_en,
  input  logic irq_acf_en,
  input  logic irq_fail_clr,
  input  logic irq_acf_clr,
  output logic bus_rst_drv,
  output logic bus_fail_drv,
  output logic loc_halt,
  output logic loc_reset,
  output logic sysclk_drv,
  output logic sysclk_oe,
  output logic irq_fail,
  output logic irq_acf
);

  localparam logic [4:0] SYNC_IDLE = 5'b11011;

  logic [4:0] sync_a, sync_b;
  logic brst_s, req_s, halt_s, fail_s, acf_s;
  logic fail_prev, acf_prev;
  logic [HW-1:0] loc_cnt, drv_cnt;
  logic [TW-1:0] halt_cnt;
  logic [1:0] own_hist;
  logic [DIV_LOG2-1:0] div;
  logic boot_fail, loc_active, halt_expired, own_recent, fail_fall, acf_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= SYNC_IDLE;
      sync_b <= SYNC_IDLE;
    end else begin
      sync_a <= {acfail_n_in, bus_fail_n_in, halt_in, loc_rst_req_n, bus_rst_n_in};
      sync_b <= sync_a;
    end

  assign {acf_s, fail_s, halt_s, req_s, brst_s} = sync_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                loc_cnt <= '0;
    else if (!brst_s)          loc_cnt <= HW'(RST_HOLD);
    else if (loc_cnt != '0)    loc_cnt <= loc_cnt - 1'b1;

  assign loc_active = !brst_s || (loc_cnt != '0);
  assign loc_halt   = loc_active;
  assign loc_reset  = loc_active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     drv_cnt <= '0;
    else if (ctrl_mode && !req_s)   drv_cnt <= HW'(RST_HOLD);
    else if (drv_cnt != '0)         drv_cnt <= drv_cnt - 1'b1;

  assign bus_rst_drv = ctrl_mode && (!req_s || (drv_cnt != '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              halt_cnt <= '0;
    else if (!halt_s || loc_active)          halt_cnt <= '0;
    else if (halt_cnt != TW'(HALT_TIMEOUT))  halt_cnt <= halt_cnt + 1'b1;

  assign halt_expired = (halt_cnt == TW'(HALT_TIMEOUT));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        boot_fail <= 1'b1;
    else if (!brst_s)  boot_fail <= 1'b1;
    else if (!fail_en) boot_fail <= 1'b0;

  assign bus_fail_drv = fail_en && !fail_inhibit && (boot_fail || halt_expired);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      own_hist  <= '0;
      fail_prev <= 1'b1;
      acf_prev  <= 1'b1;
    end else begin
      own_hist  <= {own_hist[0], bus_fail_drv};
      fail_prev <= fail_s;
      acf_prev  <= acf_s;
    end

  assign own_recent = bus_fail_drv || (own_hist != '0);
  assign fail_fall  = fail_prev && !fail_s && !own_recent;
  assign acf_fall   = acf_prev && !acf_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        irq_fail <= 1'b0;
    else if (!brst_s)                  irq_fail <= 1'b0;
    else if (fail_fall && irq_fail_en) irq_fail <= 1'b1;
    else if (irq_fail_clr)             irq_fail <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      irq_acf <= 1'b0;
    else if (!brst_s)                irq_acf <= 1'b0;
    else if (acf_fall && irq_acf_en) irq_acf <= 1'b1;
    else if (irq_acf_clr)            irq_acf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;

  assign sysclk_drv = div[DIV_LOG2-1];
  assign sysclk_oe  = ctrl_mode;

endmodule

// File: rtl/bkp_rst_supervisor_chk.sv
module bkp_rst_supervisor_chk #(
  parameter int unsigned RST_HOLD = 12_800_000,
  parameter int unsigned DIV_LOG2 = 2,
  localparam int HALF = 2 ** (DIV_LOG2 - 1)
) (
  input logic clk,
  input logic rst_n,
  input logic ctrl_mode,
  input logic fail_en,
  input logic fail_inhibit,
  input logic irq_fail_en,
  input logic irq_acf_en,
  input logic bus_rst_drv,
  input logic bus_fail_drv,
  input logic loc_reset,
  input logic sysclk_drv,
  input logic irq_fail,
  input logic irq_acf
);

  logic [31:0] run_len;
  logic [7:0]  age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          run_len <= '0;
    else if (loc_reset)  run_len <= run_len + 1'b1;
    else                 run_len <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             age <= '0;
    else if (age != 8'hff)  age <= age + 1'b1;

  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loc_reset) |-> (run_len >= 32'(RST_HOLD)));

  // R3
  ctrl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_drv |-> ctrl_mode);

  // R7
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_inhibit |-> !bus_fail_drv);

  // R7
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_en |-> !bus_fail_drv);

  // R8
  fail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_fail_en && !irq_fail) |=> !irq_fail);

  // R9
  acf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_acf_en && !irq_acf) |=> !irq_acf);

  // R11
  sysclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(age) > HALF) |-> (sysclk_drv != $past(sysclk_drv, HALF)));

endmodule

bind bkp_rst_supervisor bkp_rst_supervisor_chk #(
  .RST_HOLD(RST_HOLD), .DIV_LOG2(DIV_LOG2)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_mode(ctrl_mode), .fail_en(fail_en),
  .fail_inhibit(fail_inhibit), .irq_fail_en(irq_fail_en), .irq_acf_en(irq_acf_en),
  .bus_rst_drv(bus_rst_drv), .bus_fail_drv(bus_fail_drv), .loc_reset(loc_reset),
  .sysclk_drv(sysclk_drv), .irq_fail(irq_fail), .irq_acf(irq_acf)
);

// File: tb/bkp_rst_supervisor_tb_top.sv
module bkp_rst_supervisor_tb_top;
  localparam int H = 40;
  localparam int T = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_brst_n, loc_rst_req_n, halt_in, ext_fail_n, acfail_n_in;
  logic ctrl_mode, fail_en, fail_inhibit, irq_fail_en, irq_acf_en, irq_fail_clr, irq_acf_clr;
  logic bus_rst_drv, bus_fail_drv, loc_halt, loc_reset, sysclk_drv, sysclk_oe, irq_fail, irq_acf;
  logic bus_rst_n_in, bus_fail_n_in;
  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign bus_rst_n_in  = ext_brst_n & ~bus_rst_drv;
  assign bus_fail_n_in = ext_fail_n & ~bus_fail_drv;

  bkp_rst_supervisor #(.RST_HOLD(H), .HALT_TIMEOUT(T), .DIV_LOG2(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rst_n_in(bus_rst_n_in), .loc_rst_req_n(loc_rst_req_n),
    .halt_in(halt_in), .bus_fail_n_in(bus_fail_n_in), .acfail_n_in(acfail_n_in),
    .ctrl_mode(ctrl_mode), .fail_en(fail_en), .fail_inhibit(fail_inhibit),
    .irq_fail_en(irq_fail_en), .irq_acf_en(irq_acf_en), .irq_fail_clr(irq_fail_clr),
    .irq_acf_clr(irq_acf_clr), .bus_rst_drv(bus_rst_drv), .bus_fail_drv(bus_fail_drv),
    .loc_halt(loc_halt), .loc_reset(loc_reset), .sysclk_drv(sysclk_drv),
    .sysclk_oe(sysclk_oe), .irq_fail(irq_fail), .irq_acf(irq_acf)
  );

  function automatic int exp_release_edges(input int hold);
    return hold + 2;
  endfunction

  function automatic logic exp_irq(input logic prev, input logic en, input logic clr);
    return en ? 1'b1 : (prev & ~clr);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges_until(input int sel, input logic lvl, output int n);
    logic v;
    n = 0;
    for (int i = 0; i < 400; i++) begin
      tick(1);
      n++;
      case (sel)
        0: v = loc_reset;
        1: v = bus_rst_drv;
        default: v = bus_fail_drv;
      endcase
      if (v == lvl) return;
    end
    n = -1;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic ok;
    logic s[8];
    logic exp_acf;
    void'($urandom(32'd4711));
    rst_n = 0; ext_brst_n = 1; loc_rst_req_n = 1; halt_in = 0; ext_fail_n = 1; acfail_n_in = 1;
    ctrl_mode = 0; fail_en = 1; fail_inhibit = 0; irq_fail_en = 0; irq_acf_en = 0;
    irq_fail_clr = 0; irq_acf_clr = 0;
    tick(3);
    rst_n = 1;
    tick(4);
    check("R1 loc_reset", loc_reset, 0);
    check("R1 loc_halt", loc_halt, 0);
    check("R1 bus_rst_drv", bus_rst_drv, 0);
    check("R1 irq_fail", irq_fail, 0);
    check("R1 irq_acf", irq_acf, 0);
    check("R1 boot fail drive", bus_fail_drv, 1);

    fail_inhibit = 1; tick(1);
    check("R7 inhibit", bus_fail_drv, 0);
    fail_inhibit = 0; tick(1);
    check("R7 inhibit released", bus_fail_drv, 1);
    fail_en = 0; tick(2);
    check("R7 enable low", bus_fail_drv, 0);
    fail_en = 1; tick(1);
    check("R7 boot fail discarded", bus_fail_drv, 0);

    check("R11 oe off", sysclk_oe, 0);
    ctrl_mode = 1; tick(1);
    check("R11 oe on", sysclk_oe, 1);
    for (int i = 0; i < 8; i++) begin s[i] = sysclk_drv; tick(1); end
    ok = 1;
    for (int i = 0; i < 4; i++) if (s[i] == s[i+2] || s[i] != s[i+4]) ok = 0;
    check("R11 period", ok, 1);

    loc_rst_req_n = 0; tick(2);
    check("R3 request drives", bus_rst_drv, 1);
    tick(5);
    loc_rst_req_n = 1;
    edges_until(1, 1'b0, n);
    check("R3 hold length", n, exp_release_edges(H));
    tick(2 * H + 10);
    loc_rst_req_n = 0; tick(3); loc_rst_req_n = 1;
    tick(H / 2);
    check("R3 still held", bus_rst_drv, 1);
    loc_rst_req_n = 0; tick(3); loc_rst_req_n = 1;
    edges_until(1, 1'b0, n);
    check("R3 restart length", n, exp_release_edges(H));
    tick(2 * H + 10);
    ctrl_mode = 0;
    loc_rst_req_n = 0; tick(6);
    check("R3 ignored without controller mode", bus_rst_drv, 0);
    check("R3 no local reset without controller mode", loc_reset, 0);
    loc_rst_req_n = 1; tick(3);

    fail_en = 0; tick(2); fail_en = 1; tick(1);
    ext_brst_n = 0; tick(2);
    check("R2 loc_reset asserted", loc_reset, 1);
    check("R2 loc_halt asserted", loc_halt, 1);
    tick(10);
    ext_brst_n = 1;
    edges_until(0, 1'b0, n);
    check("R2 hold length", n, exp_release_edges(H));

    fail_en = 0; tick(2); fail_en = 1; tick(1);
    irq_acf_en = 1;
    acfail_n_in = 0; tick(3);
    check("R9 acf set", irq_acf, 1);
    acfail_n_in = 1; tick(4);
    check("R9 acf sticky", irq_acf, 1);
    ext_brst_n = 0; tick(4); ext_brst_n = 1;
    tick(2 * H + 10);
    check("R4 irq cleared by bus reset", irq_acf, 0);
    check("R4 fail re-armed by bus reset", bus_fail_drv, 1);
    fail_en = 0; tick(2); fail_en = 1; tick(1);
    check("R4 fail discarded again", bus_fail_drv, 0);

    irq_fail_en = 1;
    halt_in = 1;
    edges_until(2, 1'b1, n);
    check("R5 timeout edges", n, T + 2);
    tick(5);
    check("R8 own drive gives no irq", irq_fail, 0);
    halt_in = 0; tick(3);
    check("R5 drops after halt", bus_fail_drv, 0);
    halt_in = 1; tick(T / 2); halt_in = 0; tick(4);
    halt_in = 1;
    edges_until(2, 1'b1, n);
    check("R5 restart edges", n, T + 2);
    halt_in = 0; tick(4);
    irq_fail_en = 0;

    halt_in = 1;
    ext_brst_n = 0; tick(4); ext_brst_n = 1;
    tick(4);
    fail_en = 0; tick(1); fail_en = 1;
    edges_until(0, 1'b0, n);
    check("R6 no drive at hold end", bus_fail_drv, 0);
    edges_until(2, 1'b1, n);
    check("R6 timeout after hold", n, T);
    halt_in = 0; tick(4);

    irq_fail_en = 1;
    ext_fail_n = 0; tick(2);
    check("R8 not yet set", irq_fail, 0);
    tick(1);
    check("R8 set on assertion", irq_fail, 1);
    ext_fail_n = 1; tick(5);
    check("R8 sticky", irq_fail, 1);
    irq_fail_clr = 1; tick(1); irq_fail_clr = 0;
    check("R8 cleared", irq_fail, 0);
    irq_fail_en = 0;
    ext_fail_n = 0; tick(5); ext_fail_n = 1; tick(4);
    check("R8 disabled", irq_fail, 0);

    irq_fail_en = 1;
    ext_fail_n = 0; tick(2);
    irq_fail_clr = 1; tick(1); irq_fail_clr = 0;
    check("R10 set wins over clear", irq_fail, 1);
    ext_fail_n = 1; tick(3);
    irq_fail_clr = 1; tick(1); irq_fail_clr = 0;
    irq_acf_clr = 1; tick(1); irq_acf_clr = 0;
    acfail_n_in = 0; tick(2);
    irq_acf_clr = 1; tick(1); irq_acf_clr = 0;
    check("R10 acf set wins over clear", irq_acf, 1);
    acfail_n_in = 1; tick(3);
    irq_acf_clr = 1; tick(1); irq_acf_clr = 0;

    exp_acf = 0;
    for (int k = 0; k < 24; k++) begin
      logic en, clr;
      en = 1'($urandom % 2);
      irq_acf_en = en;
      acfail_n_in = 0; tick(2 + int'($urandom % 5));
      acfail_n_in = 1; tick(4);
      exp_acf = exp_irq(exp_acf, en, 1'b0);
      check("R9 random set", irq_acf, exp_acf);
      clr = 1'($urandom % 2);
      if (clr) begin
        irq_acf_clr = 1; tick(1); irq_acf_clr = 0;
        exp_acf = exp_irq(exp_acf, 1'b0, 1'b1);
        check("R9 random clear", irq_acf, exp_acf);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule